// File: doc/BRIEF.md
# Configurable UART Transmit Character Framer

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. Each frame is shaped by a small set of line-control fields: the character length (5 to 8 bits), whether a parity bit is sent and how it is formed, and the length of the stop period. A break request can also be raised at any time.

Timing comes from an oversampling tick that pulses sixteen times per bit period. Counting sub-ticks is what makes an exact one-and-a-half stop period possible. A single holding slot accepts a character while the previous one is still shifting. The ready flag shows when that slot is free. The transmitter-empty flag shows that the slot is free and no frame is on the line.

A break drives the line low only at the output stage. The sequencer keeps running, so software can wait for the empty flag, raise break, send a dummy character to time the break, wait for empty again and then drop break.

Top module: `utx_framer`

## Requirements
- R1: After reset, `ser_out` is 1, `ready` is 1 and `tx_empty` is 1.
- R2: Between frames the line is 1. A frame begins one clock after a character is in the holding slot and the line is idle. It opens with a start bit of 0, followed by the data bits least significant first. Every start, data and parity bit lasts OS_RATE (16) ticks of `os_tick`.
- R3: `len_sel` sets the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `data_in` above the selected length are never sent.
- R4: The stop period is high. It lasts 16 ticks when `stop_long` is 0. When `stop_long` is 1 it lasts 24 ticks (1.5 bits) if `len_sel` is 0, and 32 ticks otherwise.
- R5: With `par_en` at 0, no parity bit is sent and the stop period follows the last data bit directly.
- R6: With `par_en` at 1 and `par_stick` at 0, one parity bit follows the data. If `par_even` is 0, the total count of ones in the data and parity bits is odd. If `par_even` is 1, that count is even.
- R7: With `par_en` at 1 and `par_stick` at 1, the parity bit is 1 when `par_even` is 0 and 0 when `par_even` is 1.
- R8: While `brk_req` is 1, `ser_out` is 0. The frame sequencing and all flags continue to advance exactly as they would without break.
- R9: A `load` pulse while `ready` is 1 captures the character, and `ready` is 0 on the next cycle. A `load` pulse while `ready` is 0 is ignored and changes no transmitted bit.
- R10: `tx_empty` is 1 exactly when the holding slot is free and no frame is in progress.
- R11: The control fields are captured together with the character at `load`. Changing them later does not alter that character's frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit period |
| load | input | 1 | Character load strobe |
| data_in | input | 8 | Character to send |
| len_sel | input | 2 | Character length code |
| stop_long | input | 1 | Long stop period select |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even parity / stick level select |
| par_stick | input | 1 | Constant parity select |
| brk_req | input | 1 | Force line low (break) |
| ser_out | output | 1 | Serial line |
| tx_empty | output | 1 | Holding slot free and line idle |
| ready | output | 1 | Holding slot free |

## Verification
A wrong sub-tick count or bit index shows on `ser_out` as a transition that is late or early by at least one tick. The per-clock comparison catches it within the bit period where it happens. A wrong captured length, parity or stop setting shows up as an extra, missing or inverted bit. It also moves the moment `tx_empty` rises, which is visible at the end of the same frame. A slot-handling error shows as a `ready` mismatch one clock after the `load`, or as a frame carrying the wrong character.

// File: rtl/utx_pkg.sv
// Package: shared types and helpers for the UART transmit framer.
// Assumes characters of at most CHAR_MAX bits and a 2-bit length code.
package utx_pkg;

    localparam int CHAR_MAX = 8;
    localparam int CHAR_MIN = 5;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } phase_t;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       stop_long;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } frame_cfg_t;

    // Number of data bits selected by a length code
    function automatic int unsigned char_len(input logic [1:0] code);
        return CHAR_MIN + int'(code);
    endfunction

endpackage

// File: rtl/utx_hold.sv
// Module: utx_hold
// One-entry holding slot for a character and its framing fields.
// Assumes load and take are never both honoured in one cycle:
// take only occurs while the slot is full, load only while empty.
module utx_hold
    import utx_pkg::*;
#(
    parameter int DW = CHAR_MAX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          take,
    input  logic [DW-1:0] din,
    input  frame_cfg_t    cfg_in,
    output logic          valid,
    output logic [DW-1:0] dout,
    output frame_cfg_t    cfg_out
);

    // Capture on an accepted load, release when the sequencer takes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid   <= 1'b0;
            dout    <= '0;
            cfg_out <= '0;
        end else if (load && !valid) begin
            valid   <= 1'b1;
            dout    <= din;
            cfg_out <= cfg_in;
        end else if (take) begin
            valid   <= 1'b0;
        end
    end

endmodule

// File: rtl/utx_parity.sv
// Module: utx_parity
// Computes the parity bit for a held character from its framing fields.
// Assumes the length code selects the low CHAR_MIN..CHAR_MAX bits.
module utx_parity
    import utx_pkg::*;
#(
    parameter int DW = CHAR_MAX
) (
    input  logic [DW-1:0] data,
    input  frame_cfg_t    cfg,
    output logic          par_bit
);

    logic [DW-1:0] mask;
    logic          ones_odd;

    // Build a mask covering only the selected character bits
    for (genvar i = 0; i < DW; i++) begin : g_mask
        assign mask[i] = (i < char_len(cfg.len_sel));
    end

    assign ones_odd = ^(data & mask);

    // Select stick level, or the bit that makes the total odd/even
    always_comb begin
        if (cfg.par_stick)
            par_bit = ~cfg.par_even;
        else if (cfg.par_even)
            par_bit = ones_odd;
        else
            par_bit = ~ones_odd;
    end

endmodule

// File: rtl/utx_seq.sv
// Module: utx_seq
// Frame sequencer: walks start, data, optional parity and stop periods,
// counting OS_RATE oversampling ticks per bit and a half bit for 1.5 stop.
// Assumes OS_RATE is even and at least 2.
module utx_seq
    import utx_pkg::*;
#(
    parameter int OS_RATE = 16,
    parameter int DW      = CHAR_MAX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          have_char,
    input  logic [DW-1:0] char_in,
    input  frame_cfg_t    cfg_in,
    input  logic          par_in,
    output logic          take,
    output logic          line,
    output phase_t        phase
);

    localparam int HALF     = OS_RATE / 2;
    localparam int STOP_MAX = 2 * OS_RATE;
    localparam int CNT_W    = $clog2(STOP_MAX + 1);
    localparam int IDX_W    = $clog2(DW);
    localparam logic [CNT_W-1:0] BIT_LAST   = CNT_W'(OS_RATE - 1);
    localparam logic [CNT_W-1:0] STOP1_LAST = CNT_W'(OS_RATE - 1);
    localparam logic [CNT_W-1:0] STOPH_LAST = CNT_W'(OS_RATE + HALF - 1);
    localparam logic [CNT_W-1:0] STOP2_LAST = CNT_W'(STOP_MAX - 1);

    logic [CNT_W-1:0] tcnt;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] stop_last;
    logic [CNT_W-1:0] stop_sel;
    logic [IDX_W-1:0] bidx;
    logic [IDX_W-1:0] last_idx;
    logic [DW-1:0]    shreg;
    logic             par_en_r;
    logic             par_r;
    logic             period_end;

    assign take = (phase == PH_IDLE) && have_char;

    // Choose the stop length from the captured fields
    always_comb begin
        if (!cfg_in.stop_long)
            stop_sel = STOP1_LAST;
        else if (cfg_in.len_sel == 2'b00)
            stop_sel = STOPH_LAST;
        else
            stop_sel = STOP2_LAST;
    end

    // Tick limit of the current period
    always_comb begin
        limit = (phase == PH_STOP) ? stop_last : BIT_LAST;
    end

    assign period_end = tick && (tcnt == limit);

    // Phase, counters and shifter update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            tcnt      <= '0;
            bidx      <= '0;
            last_idx  <= '0;
            shreg     <= '0;
            par_en_r  <= 1'b0;
            par_r     <= 1'b0;
            stop_last <= STOP1_LAST;
        end else if (phase == PH_IDLE) begin
            if (take) begin
                phase     <= PH_START;
                tcnt      <= '0;
                bidx      <= '0;
                last_idx  <= IDX_W'(char_len(cfg_in.len_sel) - 1);
                shreg     <= char_in;
                par_en_r  <= cfg_in.par_en;
                par_r     <= par_in;
                stop_last <= stop_sel;
            end
        end else if (tick) begin
            if (period_end) begin
                tcnt <= '0;
                case (phase)
                    PH_START: phase <= PH_DATA;
                    PH_DATA: begin
                        shreg <= shreg >> 1;
                        if (bidx == last_idx)
                            phase <= par_en_r ? PH_PARITY : PH_STOP;
                        else
                            bidx <= bidx + 1'b1;
                    end
                    PH_PARITY: phase <= PH_STOP;
                    default:   phase <= PH_IDLE;
                endcase
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // Line level for the current period
    always_comb begin
        case (phase)
            PH_START:  line = 1'b0;
            PH_DATA:   line = shreg[0];
            PH_PARITY: line = par_r;
            default:   line = 1'b1;
        endcase
    end

endmodule

// File: rtl/utx_line_out.sv
// Module: utx_line_out
// Output stage: a break request forces the line low, nothing else.
// Assumes the frame logic upstream is unaware of the break.
module utx_line_out (
    input  logic brk,
    input  logic line_in,
    output logic line_out
);

    // Force low during break, otherwise pass the frame level
    always_comb begin
        line_out = brk ? 1'b0 : line_in;
    end

endmodule

// File: rtl/utx_framer.sv
// Module: utx_framer
// UART transmit character framer top: holding slot, parity generator,
// frame sequencer and break output stage.
// Assumes os_tick pulses OS_RATE times per bit period, one cycle wide.
module utx_framer
    import utx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       load,
    input  logic [7:0] data_in,
    input  logic [1:0] len_sel,
    input  logic       stop_long,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       par_stick,
    input  logic       brk_req,
    output logic       ser_out,
    output logic       tx_empty,
    output logic       ready
);

    localparam int DW = CHAR_MAX;

    frame_cfg_t    cfg_now;
    frame_cfg_t    cfg_held;
    logic [DW-1:0] data_held;
    logic          held;
    logic          take;
    logic          par_bit;
    logic          frame_line;
    phase_t        cur_phase;

    assign cfg_now = '{len_sel: len_sel, stop_long: stop_long, par_en: par_en,
                       par_even: par_even, par_stick: par_stick};

    utx_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .take    (take),
        .din     (data_in),
        .cfg_in  (cfg_now),
        .valid   (held),
        .dout    (data_held),
        .cfg_out (cfg_held)
    );

    utx_parity #(.DW(DW)) u_par (
        .data    (data_held),
        .cfg     (cfg_held),
        .par_bit (par_bit)
    );

    utx_seq #(.OS_RATE(OS_RATE), .DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (os_tick),
        .have_char (held),
        .char_in   (data_held),
        .cfg_in    (cfg_held),
        .par_in    (par_bit),
        .take      (take),
        .line      (frame_line),
        .phase     (cur_phase)
    );

    utx_line_out u_out (
        .brk      (brk_req),
        .line_in  (frame_line),
        .line_out (ser_out)
    );

    assign ready    = !held;
    assign tx_empty = !held && (cur_phase == PH_IDLE);

endmodule

// File: rtl/utx_framer_chk.sv
// Module: utx_framer_chk
// Protocol checker for utx_framer, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module utx_framer_chk
    import utx_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   load,
    input logic   brk,
    input logic   ser_out,
    input logic   tx_empty,
    input logic   ready,
    input phase_t phase
);

    AST_BREAK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        brk |-> !ser_out); // R8
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !brk) |-> ser_out); // R2
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_START) |-> !ser_out); // R2
    AST_STOP_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STOP && !brk) |-> ser_out); // R4
    AST_EMPTY_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> ready); // R10
    AST_EMPTY_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (phase == PH_IDLE)); // R10
    AST_LOAD_FILLS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ready) |=> !ready); // R9

endmodule

bind utx_framer utx_framer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .brk      (brk_req),
    .ser_out  (ser_out),
    .tx_empty (tx_empty),
    .ready    (ready),
    .phase    (cur_phase)
);

// File: tb/utx_framer_test.sv
module utx_framer_test;

    localparam int CLK_PERIOD = 10;
    localparam int OSR        = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       load = 1'b0;
    logic [7:0] data_in = '0;
    logic [1:0] len_sel = '0;
    logic       stop_long = 1'b0;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       par_stick = 1'b0;
    logic       brk_req = 1'b0;
    logic       ser_out;
    logic       tx_empty;
    logic       ready;

    int    n_checks = 0;
    int    n_fail = 0;
    int    tick_div = 1;
    int    cyc_n = 0;
    string cur_req = "R1";

    // Reference model state
    logic       m_held = 1'b0;
    logic [7:0] m_data = '0;
    int         m_len = 5;
    logic       m_long = 1'b0, m_pen = 1'b0, m_even = 1'b0, m_stick = 1'b0;
    logic       m_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    utx_framer #(.OS_RATE(OSR)) uut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .load(load),
        .data_in(data_in), .len_sel(len_sel), .stop_long(stop_long),
        .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
        .brk_req(brk_req), .ser_out(ser_out), .tx_empty(tx_empty), .ready(ready)
    );

    // Build the per-tick line levels of one frame from the requirements
    task automatic build_frame();
        int   ones = 0;
        logic p;
        int   stop_ticks;
        for (int k = 0; k < OSR; k++) m_q.push_back(1'b0);
        for (int b = 0; b < m_len; b++) begin
            if (m_data[b]) ones++;
            for (int k = 0; k < OSR; k++) m_q.push_back(m_data[b]);
        end
        if (m_pen) begin
            if (m_stick) p = !m_even;
            else if (m_even) p = (ones % 2) == 1;
            else p = (ones % 2) == 0;
            for (int k = 0; k < OSR; k++) m_q.push_back(p);
        end
        if (!m_long) stop_ticks = OSR;
        else if (m_len == 5) stop_ticks = OSR + OSR/2;
        else stop_ticks = 2*OSR;
        for (int k = 0; k < stop_ticks; k++) m_q.push_back(1'b1);
    endtask

    // Reference model update at each rising edge (inputs settled at negedge)
    always @(posedge clk) begin
        logic was_held;
        if (!rst_n) begin
            m_held = 1'b0;
            m_q.delete();
        end else begin
            was_held = m_held;
            if (m_q.size() == 0 && m_held) begin
                build_frame();
                m_held = 1'b0;
            end else if (m_q.size() != 0 && os_tick) begin
                void'(m_q.pop_front());
            end
            if (load && !was_held) begin
                m_held  = 1'b1;
                m_data  = data_in;
                m_len   = 5 + int'(len_sel);
                m_long  = stop_long;
                m_pen   = par_en;
                m_even  = par_even;
                m_stick = par_stick;
            end
        end
    end

    function automatic logic model_empty();
        return !m_held && m_q.size() == 0;
    endfunction

    // Compare all outputs against the model
    task automatic check_outputs();
        logic e_ser, e_rdy, e_emp;
        e_ser = brk_req ? 1'b0 : (m_q.size() != 0 ? m_q[0] : 1'b1);
        e_rdy = !m_held;
        e_emp = model_empty();
        n_checks++;
        if (ser_out !== e_ser || ready !== e_rdy || tx_empty !== e_emp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: ser/ready/empty got %b%b%b expected %b%b%b",
                     cur_req, cyc_n, ser_out, ready, tx_empty, e_ser, e_rdy, e_emp);
        end
    endtask

    // One clock: check at negedge, then prepare the next inputs
    task automatic cyc();
        @(negedge clk);
        check_outputs();
        cyc_n++;
        os_tick = (cyc_n % tick_div) == 0;
        load = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] l, input logic sl, input logic pe,
                           input logic ev, input logic st);
        len_sel = l; stop_long = sl; par_en = pe; par_even = ev; par_stick = st;
    endtask

    // Wait for a free slot, then load one character
    task automatic send(input logic [7:0] d, input logic [1:0] l, input logic sl,
                        input logic pe, input logic ev, input logic st);
        while (m_held) cyc();
        data_in = d;
        set_cfg(l, sl, pe, ev, st);
        load = 1'b1;
        cyc();
    endtask

    task automatic wait_empty();
        while (!model_empty()) cyc();
        repeat (3) cyc();
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (4) cyc();
        rst_n = 1'b1;
        repeat (3) cyc();

        // R2 R3: 8-bit frame, no parity, one stop, tick every cycle
        cur_req = "R2 R3 R5";
        send(8'hA5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        wait_empty();

        // R3 R4: 5-bit with upper data bits set, 1.5 stop
        cur_req = "R3 R4";
        send(8'hEB, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        wait_empty();

        // R4: 6-bit, two stop bits
        cur_req = "R4";
        send(8'h2D, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
        wait_empty();

        // R6: 7-bit even parity, then odd parity
        cur_req = "R6";
        send(8'h53, 2'b10, 1'b0, 1'b1, 1'b1, 1'b0);
        wait_empty();
        send(8'h53, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
        wait_empty();
        send(8'h00, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
        wait_empty();

        // R7: stick parity both levels
        cur_req = "R7";
        send(8'hFF, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1);
        wait_empty();
        send(8'hFF, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1);
        wait_empty();

        // R9 R10: slower tick, back-to-back loads and a rejected load
        cur_req = "R9 R10";
        tick_div = 3;
        send(8'h81, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
        send(8'h3C, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
        data_in = 8'hFF;
        set_cfg(2'b11, 1'b1, 1'b1, 1'b0, 1'b1);
        load = 1'b1;
        cyc();
        wait_empty();

        // R11: change fields in mid-frame
        cur_req = "R11";
        tick_div = 2;
        send(8'h96, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
        repeat (40) cyc();
        set_cfg(2'b00, 1'b1, 1'b0, 1'b1, 1'b1);
        wait_empty();

        // R8: break timed by a dummy character
        cur_req = "R8";
        tick_div = 1;
        brk_req = 1'b1;
        send(8'h00, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
        wait_empty();
        brk_req = 1'b0;
        repeat (3) cyc();

        // R2: line returns to normal framing after break
        cur_req = "R2 R8";
        send(8'h5A, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        wait_empty();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule